// File: doc/BRIEF.md
# Sector Erase/Program Sequencer

This block is the control core of a byte-wide nonvolatile memory model. It sits in front of a small flop-based cell array and runs two self-timed operations: a byte program, which can only turn 1 bits into 0 bits, and an erase, which returns whole sectors to 0xFF. The address space is 19 bits wide and has eight equal sectors. The top three address bits pick the sector. The stand-in array keeps only `OFS_BITS` low offset bits per sector, so higher offset bits alias. Reset loads every cell with the erased value.

A host uses a chip-enable/write-enable/output-enable bus. A write cycle has chip enable and write enable low, and it carries a 3-bit command code together with the address and data. A read cycle has chip enable and output enable low with write enable high, and it returns a registered byte one clock later. While an operation runs, a read returns a status byte instead of array contents. Bit 7 of that byte is for data polling, bit 6 alternates on every status read, and bit 2 reports whether the addressed sector is still queued for erase.

Sectors are queued for erase one at a time, or all at once, and the queue is then started. An erase in progress can be frozen with a suspend command. While it is frozen, sectors outside the queue can be read or programmed. A resume command then continues the erase from where it stopped. A per-sector lock input blocks all programming and erasing of the sectors it marks.

Top module: `flash_sector_seq`

## Requirements
- R1: After reset, `bus_rdata` is 0x00, no operation is running, and every byte reads back as 0xFF.
- R2: A read cycle (ce_n=0, oe_n=0, we_n=1) loads `bus_rdata` at the next clock edge. The sector is `bus_addr[18:16]` and the byte is `bus_addr[OFS_BITS-1:0]`; the offset bits above that are ignored. `bus_rdata` holds its value on cycles that are not reads.
- R3: Command code 1 (program) stores old AND new at the addressed byte. The operation stays busy for `PROG_CYC`+1 cycles after the write cycle that accepted it, and the new value becomes visible once the operation finishes.
- R4: During a program, a read returns bit 7 equal to the complement of bit 7 of the byte being written, bit 6 as the alternating toggle, bit 2 as described in R8, and 0 in bits 5:3 and 1:0.
- R5: When `sect_lock[s]` is 1, commands to program sector s or to queue it (codes 1, 2, 4) have no effect. A queued sector that is locked by the time its erase step arrives is left unchanged.
- R6: Code 2 queues the addressed sector. Code 3 starts the erase of all queued sectors in ascending order, each taking `ERASE_CYC`+1 cycles, and leaves them at 0xFF. Code 3 with an empty queue does nothing.
- R7: Code 4 queues every unlocked sector and starts the erase at once.
- R8: During an erase, a status read has bit 7 = 0 and bit 6 as the toggle. Bit 2 alternates on successive reads of any sector still queued, and it is 0 for a sector that is not queued.
- R9: Code 5 sent during an erase step freezes the erase from the next cycle on. Reads of sectors that are not queued return array data. Reads of queued sectors return bit 7 = 1, bit 6 = 0 and bit 2 alternating.
- R10: While suspended, code 1 to an unlocked sector that is not queued runs a normal program and then returns to the suspended state. Code 1 to a queued sector is ignored.
- R11: Code 6 resumes a suspended erase with the remaining cycle count and queue intact.
- R12: While busy, every command other than suspend is ignored. Suspend and resume are ignored when no erase is running or suspended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_addr | input | 19 | Byte address; bits 18:16 select the sector |
| bus_wdata | input | 8 | Data byte for program |
| bus_cmd | input | 3 | Command code sampled on a write cycle |
| sect_lock | input | 8 | Per-sector protection, 1 = locked |
| bus_rdata | output | 8 | Registered read data or status |

## Verification
The hardest state to reach is a program that runs inside a suspended erase. It needs an erase started on a two-sector queue, a suspend landing during the first sector's count, and reads on both sides of the queue boundary before and after a nested program. The stimulus queues two sectors and starts them, then waits a few cycles and suspends. It then idles long enough to show that the erase is frozen, programs an unqueued sector, tries to program a queued one, and resumes. A reference model compares `bus_rdata` on every cycle, so toggle phases and the point at which each sector clears are all checked.

// File: rtl/fss_pkg.sv
// Shared command and state encodings for the sector erase/program sequencer.
package fss_pkg;

    typedef enum logic [2:0] {
        CMD_NONE   = 3'd0,
        CMD_PROG   = 3'd1,
        CMD_MARK   = 3'd2,
        CMD_START  = 3'd3,
        CMD_CHIP   = 3'd4,
        CMD_SUSP   = 3'd5,
        CMD_RESUME = 3'd6,
        CMD_RSVD   = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_PVFY,
        ST_ERASE,
        ST_EVFY,
        ST_SUSP
    } seq_st_e;

endpackage

// File: rtl/fss_cell_array.sv
// Flop-based cell array. Program ANDs the new byte into one cell (bits only
// clear); sector clear sets every cell of one sector to all ones in one cycle.
// Assumes the sequencer never requests program and clear together.
module fss_cell_array #(
    parameter int SECT_BITS = 3,
    parameter int OFS_BITS  = 4,
    parameter int DATA_W    = 8,
    localparam int SECTORS  = 1 << SECT_BITS,
    localparam int DEPTH    = 1 << OFS_BITS,
    localparam int IDX_W    = SECT_BITS + OFS_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pgm_en,
    input  logic [IDX_W-1:0]     pgm_idx,
    input  logic [DATA_W-1:0]    pgm_data,
    input  logic                 clr_en,
    input  logic [SECT_BITS-1:0] clr_sec,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [DATA_W-1:0]    rd_data
);

    logic [DATA_W-1:0]  cells [SECTORS][DEPTH];
    logic [SECTORS-1:0] clr_hit;

    // Per-sector clear decode.
    for (genvar gs = 0; gs < SECTORS; gs++) begin : g_clr
        assign clr_hit[gs] = clr_en && (clr_sec == SECT_BITS'(gs));
    end

    // Cell update: reset to erased, sector clear, or bit-clearing program.
    always_ff @(posedge clk) begin
        for (int s = 0; s < SECTORS; s++) begin
            for (int o = 0; o < DEPTH; o++) begin
                if (!rst_n) begin
                    cells[s][o] <= '1;
                end else if (clr_hit[s]) begin
                    cells[s][o] <= '1;
                end else if (pgm_en && pgm_idx == IDX_W'(s * DEPTH + o)) begin
                    cells[s][o] <= cells[s][o] & pgm_data;
                end
            end
        end
    end

    // Asynchronous read port.
    assign rd_data = cells[rd_idx[IDX_W-1:OFS_BITS]][rd_idx[OFS_BITS-1:0]];

    // R3 / R6: the sequencer must not program and clear in the same cycle.
    a_r3_single_op: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_en && clr_en));

endmodule

// File: rtl/fss_sequencer.sv
// Operation sequencer. Accepts host commands, times program and erase with
// separate counters (so a program inside a suspended erase keeps the erase
// count), walks the erase queue from the lowest sector up and applies locks.
// Assumes at most one command per write strobe.
module fss_sequencer
    import fss_pkg::*;
#(
    parameter int SECT_BITS = 3,
    parameter int OFS_BITS  = 4,
    parameter int DATA_W    = 8,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 20,
    localparam int SECTORS  = 1 << SECT_BITS,
    localparam int IDX_W    = SECT_BITS + OFS_BITS,
    localparam int PCNT_W   = $clog2(PROG_CYC + 1),
    localparam int ECNT_W   = $clog2(ERASE_CYC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_stb,
    input  cmd_e                 cmd,
    input  logic [SECT_BITS-1:0] wr_sec,
    input  logic [IDX_W-1:0]     wr_idx,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [SECTORS-1:0]   lock,
    output logic                 pgm_en,
    output logic [IDX_W-1:0]     pgm_idx,
    output logic [DATA_W-1:0]    pgm_data,
    output logic                 clr_en,
    output logic [SECT_BITS-1:0] clr_sec,
    output logic                 busy,
    output logic                 prog_phase,
    output logic                 suspended,
    output logic [SECTORS-1:0]   eset
);

    localparam logic [PCNT_W-1:0] PROG_LAST  = PCNT_W'(PROG_CYC - 1);
    localparam logic [ECNT_W-1:0] ERASE_LAST = ECNT_W'(ERASE_CYC - 1);

    seq_st_e              state;
    logic [PCNT_W-1:0]    pcnt;
    logic [ECNT_W-1:0]    ecnt;
    logic                 back_susp;
    logic [SECT_BITS-1:0] cur_sec;
    logic                 susp_req;
    logic [SECTORS-1:0]   rest;

    // Lowest queued sector is the one being erased.
    always_comb begin
        cur_sec = '0;
        for (int s = SECTORS - 1; s >= 0; s--) begin
            if (eset[s]) cur_sec = SECT_BITS'(s);
        end
    end

    // Queue with the current sector removed.
    assign rest     = eset & ~(SECTORS'(1) << cur_sec);
    assign susp_req = wr_stb && (cmd == CMD_SUSP);

    // Main operation state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pcnt      <= '0;
            ecnt      <= '0;
            eset      <= '0;
            pgm_idx   <= '0;
            pgm_data  <= '0;
            back_susp <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (wr_stb) begin
                    case (cmd)
                        CMD_PROG: if (!lock[wr_sec]) begin
                            state     <= ST_PROG;
                            pcnt      <= PROG_LAST;
                            pgm_idx   <= wr_idx;
                            pgm_data  <= wr_data;
                            back_susp <= 1'b0;
                        end
                        CMD_MARK: if (!lock[wr_sec]) eset[wr_sec] <= 1'b1;
                        CMD_START: if (eset != '0) begin
                            state <= ST_ERASE;
                            ecnt  <= ERASE_LAST;
                        end
                        CMD_CHIP: if (~lock != '0) begin
                            eset  <= ~lock;
                            state <= ST_ERASE;
                            ecnt  <= ERASE_LAST;
                        end
                        default: ;
                    endcase
                end
                ST_PROG: begin
                    if (pcnt == '0) state <= ST_PVFY;
                    else            pcnt  <= pcnt - 1'b1;
                end
                ST_PVFY: begin
                    state     <= back_susp ? ST_SUSP : ST_IDLE;
                    back_susp <= 1'b0;
                end
                ST_ERASE: begin
                    if (susp_req)          state <= ST_SUSP;
                    else if (ecnt == '0)   state <= ST_EVFY;
                    else                   ecnt  <= ecnt - 1'b1;
                end
                ST_EVFY: begin
                    eset[cur_sec] <= 1'b0;
                    if (rest == '0) begin
                        state <= ST_IDLE;
                    end else begin
                        state <= ST_ERASE;
                        ecnt  <= ERASE_LAST;
                    end
                end
                ST_SUSP: if (wr_stb) begin
                    if (cmd == CMD_RESUME) begin
                        state <= ST_ERASE;
                    end else if (cmd == CMD_PROG && !lock[wr_sec] && !eset[wr_sec]) begin
                        state     <= ST_PROG;
                        pcnt      <= PROG_LAST;
                        pgm_idx   <= wr_idx;
                        pgm_data  <= wr_data;
                        back_susp <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Array strobes and phase flags for the read path.
    assign pgm_en     = (state == ST_PROG) && (pcnt == '0);
    assign clr_en     = (state == ST_ERASE) && (ecnt == '0) && !susp_req && !lock[cur_sec];
    assign clr_sec    = cur_sec;
    assign prog_phase = (state == ST_PROG) || (state == ST_PVFY);
    assign busy       = prog_phase || (state == ST_ERASE) || (state == ST_EVFY);
    assign suspended  = (state == ST_SUSP);

    // R5: a program aimed at a locked sector leaves the sequencer idle.
    a_r5_lock_blocks_prog: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_stb && cmd == CMD_PROG && lock[wr_sec]) |=> (state == ST_IDLE));

    // R6: the erase queue only grows while idle.
    a_r6_queue_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ((eset & ~$past(eset)) == '0));

    // R10: a program into a queued sector during suspend is refused.
    a_r10_no_prog_queued: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && wr_stb && cmd == CMD_PROG && eset[wr_sec]) |=> (state == ST_SUSP));

    // R11: without a command, a suspended erase keeps its progress.
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSP && !wr_stb) |=> (state == ST_SUSP && $stable(ecnt) && $stable(eset)));

endmodule

// File: rtl/fss_status.sv
// Read path. Registers either array data or a status byte on each read
// strobe and keeps the two toggle flops that status reads alternate.
// Assumes DATA_W is at least 8 (status bits sit at fixed positions).
module fss_status #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              busy,
    input  logic              prog_phase,
    input  logic              suspended,
    input  logic              sel_hit,
    input  logic              prog_d7,
    input  logic [DATA_W-1:0] cell_data,
    output logic [DATA_W-1:0] rdata
);

    localparam int POLL_BIT = 7;
    localparam int TOG_BIT  = 6;
    localparam int SEL_BIT  = 2;

    logic              tog_any;
    logic              tog_sel;
    logic              show_status;
    logic [DATA_W-1:0] stat;

    // Status byte for the current read.
    always_comb begin
        stat = '0;
        if (busy) begin
            stat[POLL_BIT] = prog_phase ? ~prog_d7 : 1'b0;
            stat[TOG_BIT]  = tog_any;
            stat[SEL_BIT]  = sel_hit & tog_sel;
        end else begin
            stat[POLL_BIT] = 1'b1;
            stat[SEL_BIT]  = tog_sel;
        end
    end

    assign show_status = busy || (suspended && sel_hit);

    // Output register and toggle flops, updated only on read strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata   <= '0;
            tog_any <= 1'b0;
            tog_sel <= 1'b0;
        end else if (rd_stb) begin
            rdata <= show_status ? stat : cell_data;
            if (busy)                  tog_any <= ~tog_any;
            if (show_status && sel_hit) tog_sel <= ~tog_sel;
        end
    end

    // R4 / R8: status reads during an operation leave the unused bits at zero.
    a_r4_status_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && busy) |=> (rdata[5:3] == '0 && rdata[1:0] == '0));

    // R9: a read of a queued sector while suspended shows the suspended pattern.
    a_r9_susp_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !busy && suspended && sel_hit) |=> (rdata[POLL_BIT] && !rdata[TOG_BIT]));

endmodule

// File: rtl/flash_sector_seq.sv
// Top of the sector erase/program sequencer: decodes the host bus into
// read and write strobes, splits the address into sector and offset, and
// wires the sequencer, cell array and read path together.
// Assumes OFS_BITS + SECT_BITS < ADDR_W (upper offset bits alias).
module flash_sector_seq
    import fss_pkg::*;
#(
    parameter int ADDR_W    = 19,
    parameter int DATA_W    = 8,
    parameter int SECT_BITS = 3,
    parameter int OFS_BITS  = 4,
    parameter int PROG_CYC  = 4,
    parameter int ERASE_CYC = 20,
    localparam int SECTORS  = 1 << SECT_BITS,
    localparam int IDX_W    = SECT_BITS + OFS_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_ce_n,
    input  logic               bus_we_n,
    input  logic               bus_oe_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [2:0]         bus_cmd,
    input  logic [SECTORS-1:0] sect_lock,
    output logic [DATA_W-1:0]  bus_rdata
);

    logic                 rd_stb;
    logic                 wr_stb;
    logic [SECT_BITS-1:0] sec;
    logic [IDX_W-1:0]     idx;
    logic                 addr_unused;
    logic                 pgm_en;
    logic [IDX_W-1:0]     pgm_idx;
    logic [DATA_W-1:0]    pgm_data;
    logic                 clr_en;
    logic [SECT_BITS-1:0] clr_sec;
    logic                 busy;
    logic                 prog_phase;
    logic                 suspended;
    logic [SECTORS-1:0]   eset;
    logic [DATA_W-1:0]    cell_data;

    // Bus decode: a write wins over output enable.
    assign wr_stb      = !bus_ce_n && !bus_we_n;
    assign rd_stb      = !bus_ce_n && !bus_oe_n && bus_we_n;
    assign sec         = bus_addr[ADDR_W-1 -: SECT_BITS];
    assign idx         = {sec, bus_addr[OFS_BITS-1:0]};
    assign addr_unused = ^bus_addr[ADDR_W-SECT_BITS-1:OFS_BITS];

    fss_sequencer #(
        .SECT_BITS (SECT_BITS),
        .OFS_BITS  (OFS_BITS),
        .DATA_W    (DATA_W),
        .PROG_CYC  (PROG_CYC),
        .ERASE_CYC (ERASE_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_stb     (wr_stb),
        .cmd        (cmd_e'(bus_cmd)),
        .wr_sec     (sec),
        .wr_idx     (idx),
        .wr_data    (bus_wdata),
        .lock       (sect_lock),
        .pgm_en     (pgm_en),
        .pgm_idx    (pgm_idx),
        .pgm_data   (pgm_data),
        .clr_en     (clr_en),
        .clr_sec    (clr_sec),
        .busy       (busy),
        .prog_phase (prog_phase),
        .suspended  (suspended),
        .eset       (eset)
    );

    fss_cell_array #(
        .SECT_BITS (SECT_BITS),
        .OFS_BITS  (OFS_BITS),
        .DATA_W    (DATA_W)
    ) u_array (
        .clk      (clk),
        .rst_n    (rst_n),
        .pgm_en   (pgm_en),
        .pgm_idx  (pgm_idx),
        .pgm_data (pgm_data),
        .clr_en   (clr_en),
        .clr_sec  (clr_sec),
        .rd_idx   (idx),
        .rd_data  (cell_data)
    );

    fss_status #(
        .DATA_W (DATA_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .busy       (busy),
        .prog_phase (prog_phase),
        .suspended  (suspended),
        .sel_hit    (eset[sec]),
        .prog_d7    (pgm_data[DATA_W-1]),
        .cell_data  (cell_data),
        .rdata      (bus_rdata)
    );

    // R12: nothing but a suspend moves a running erase out of the busy phase early.
    a_r12_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !prog_phase && !(wr_stb && bus_cmd == 3'd5)) |=> (busy || !suspended));

endmodule

// File: tb/flash_sector_seq_test.sv
module flash_sector_seq_test;

    localparam int P = 4;
    localparam int C = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [18:0] addr = '0;
    logic [7:0]  din = '0;
    logic [2:0]  cmd = '0;
    logic [7:0]  prot = '0;
    logic [7:0]  dout;

    int    vectors = 0;
    int    fails = 0;
    int    cycles = 0;
    string tag = "R1";

    always #4 clk = ~clk;

    flash_sector_seq #(.PROG_CYC(P), .ERASE_CYC(C)) uut (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
        .bus_addr(addr), .bus_wdata(din), .bus_cmd(cmd), .sect_lock(prot), .bus_rdata(dout)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_mem [8][16];
    int         m_mode;          // 0 idle, 1 program, 2 erase, 3 suspended
    int         m_pleft, m_eleft;
    logic       m_back;
    int         m_psec, m_pofs;
    logic [7:0] m_pd, m_sel, m_dout;
    logic       m_t6, m_t2;

    function automatic int lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    always @(posedge clk) begin
        int s, o, k;
        logic rd, wr, hit;
        logic [7:0] v;
        if (!rst_n) begin
            for (int a = 0; a < 8; a++) for (int b = 0; b < 16; b++) m_mem[a][b] = 8'hFF;
            m_mode = 0; m_pleft = 0; m_eleft = 0; m_back = 0; m_pd = 0;
            m_sel = 0; m_dout = 0; m_t6 = 0; m_t2 = 0; m_psec = 0; m_pofs = 0;
        end else begin
            s = int'(addr[18:16]); o = int'(addr[3:0]);
            rd = !ce_n && !oe_n && we_n;
            wr = !ce_n && !we_n;
            hit = m_sel[s];
            if (rd) begin
                if (m_mode == 1 || m_mode == 2) begin
                    v = 8'h00;
                    v[7] = (m_mode == 1) ? ~m_pd[7] : 1'b0;
                    v[6] = m_t6;
                    v[2] = hit ? m_t2 : 1'b0;
                    m_t6 = ~m_t6;
                    if (hit) m_t2 = ~m_t2;
                    m_dout = v;
                end else if (m_mode == 3 && hit) begin
                    v = 8'h80; v[2] = m_t2; m_t2 = ~m_t2; m_dout = v;
                end else begin
                    m_dout = m_mem[s][o];
                end
            end
            case (m_mode)
                0: if (wr) begin
                    if (cmd == 3'd1 && !prot[s]) begin
                        m_mode = 1; m_pleft = P + 1; m_back = 0; m_psec = s; m_pofs = o; m_pd = din;
                    end else if (cmd == 3'd2 && !prot[s]) m_sel[s] = 1'b1;
                    else if (cmd == 3'd3 && m_sel != 0) begin m_mode = 2; m_eleft = C + 1; end
                    else if (cmd == 3'd4 && ~prot != 0) begin m_sel = ~prot; m_mode = 2; m_eleft = C + 1; end
                end
                1: begin
                    if (m_pleft == 2) m_mem[m_psec][m_pofs] = m_mem[m_psec][m_pofs] & m_pd;
                    if (m_pleft == 1) m_mode = m_back ? 3 : 0;
                    else m_pleft--;
                end
                2: begin
                    if (wr && cmd == 3'd5 && m_eleft >= 2) m_mode = 3;
                    else if (m_eleft == 2) begin
                        k = lowest(m_sel);
                        if (!prot[k]) for (int b = 0; b < 16; b++) m_mem[k][b] = 8'hFF;
                        m_eleft = 1;
                    end else if (m_eleft == 1) begin
                        k = lowest(m_sel);
                        m_sel[k] = 1'b0;
                        if (m_sel == 0) m_mode = 0; else m_eleft = C + 1;
                    end else m_eleft--;
                end
                default: if (wr) begin
                    if (cmd == 3'd6) m_mode = 2;
                    else if (cmd == 3'd1 && !prot[s] && !m_sel[s]) begin
                        m_mode = 1; m_pleft = P + 1; m_back = 1; m_psec = s; m_pofs = o; m_pd = din;
                    end
                end
            endcase
        end
    end

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            if (dout !== m_dout) begin
                fails++;
                $display("FAIL %s: bus_rdata=%h expected %h (cycle %0d)", tag, dout, m_dout, cycles);
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL R12 watchdog: cycles=%0d expected below %0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [18:0] A(int s, int o);
        return {s[2:0], 12'h000, o[3:0]};
    endfunction

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(logic [2:0] c, logic [18:0] a, logic [7:0] d);
        @(negedge clk);
        ce_n = 0; we_n = 0; oe_n = 1; cmd = c; addr = a; din = d;
        @(negedge clk);
        ce_n = 1; we_n = 1; cmd = 3'd0;
    endtask

    task automatic do_rd(logic [18:0] a);
        @(negedge clk);
        ce_n = 0; we_n = 1; oe_n = 0; addr = a;
        @(negedge clk);
        ce_n = 1; oe_n = 1;
    endtask

    task automatic chk(string t, logic [7:0] exp);
        vectors++;
        if (dout !== exp) begin
            fails++;
            $display("FAIL %s: bus_rdata=%h expected %h", t, dout, exp);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        @(negedge clk);
        tag = "R1"; chk("R1 reset value", 8'h00);
        do_rd(A(0, 0)); chk("R1 erased after reset", 8'hFF);
        do_rd(A(7, 15)); chk("R1 erased top byte", 8'hFF);

        // Program, bit-clearing, status during program, aliasing
        tag = "R4";
        do_wr(3'd1, A(1, 3), 8'hA5);
        do_rd(A(1, 3)); do_rd(A(1, 3)); do_rd(A(0, 0));
        idle(4);
        tag = "R3";
        do_rd(A(1, 3)); chk("R3 programmed byte", 8'hA5);
        do_wr(3'd1, A(1, 3), 8'h3C);
        idle(P + 2);
        do_rd(A(1, 3)); chk("R3 only clears bits", 8'h24);
        tag = "R2";
        do_rd(A(1, 3) | 19'h00F30); chk("R2 upper offset bits alias", 8'h24);
        idle(2); chk("R2 output holds", 8'h24);

        // Locks
        tag = "R5";
        prot = 8'h04;
        do_wr(3'd1, A(2, 1), 8'h00);
        idle(P + 2);
        do_rd(A(2, 1)); chk("R5 locked sector not programmed", 8'hFF);
        do_wr(3'd2, A(2, 0), 8'h00);
        do_wr(3'd3, A(0, 0), 8'h00);
        do_rd(A(1, 3)); chk("R6 start with empty queue ignored", 8'h24);

        // Multi-sector erase with status and ignored commands
        tag = "R6";
        do_wr(3'd1, A(0, 5), 8'h11); idle(P + 2);
        do_wr(3'd1, A(3, 5), 8'h22); idle(P + 2);
        do_wr(3'd1, A(5, 9), 8'h33); idle(P + 2);
        do_wr(3'd2, A(5, 0), 8'h00);
        do_wr(3'd2, A(3, 0), 8'h00);
        do_wr(3'd3, A(0, 0), 8'h00);
        tag = "R8";
        do_rd(A(5, 9)); do_rd(A(5, 9)); do_rd(A(0, 5)); do_rd(A(3, 5));
        tag = "R12";
        do_wr(3'd1, A(0, 5), 8'h00);
        do_wr(3'd6, A(0, 0), 8'h00);
        idle(2 * (C + 1));
        tag = "R6";
        do_rd(A(3, 5)); chk("R6 sector 3 erased", 8'hFF);
        do_rd(A(5, 9)); chk("R6 sector 5 erased", 8'hFF);
        do_rd(A(0, 5)); chk("R12 program while busy ignored", 8'h11);
        tag = "R12";
        do_wr(3'd5, A(0, 0), 8'h00);
        do_wr(3'd6, A(0, 0), 8'h00);
        do_rd(A(0, 5)); chk("R12 suspend/resume when idle ignored", 8'h11);

        // Suspend, nested program, resume
        tag = "R9";
        do_wr(3'd1, A(4, 2), 8'h44); idle(P + 2);
        do_wr(3'd1, A(6, 2), 8'h66); idle(P + 2);
        do_wr(3'd2, A(4, 0), 8'h00);
        do_wr(3'd2, A(6, 0), 8'h00);
        do_wr(3'd3, A(0, 0), 8'h00);
        idle(5);
        do_wr(3'd5, A(0, 0), 8'h00);
        do_rd(A(0, 5)); chk("R9 unqueued sector readable", 8'h11);
        do_rd(A(4, 2)); do_rd(A(4, 2));
        tag = "R11";
        idle(3 * C);
        do_rd(A(4, 2));
        tag = "R10";
        do_wr(3'd1, A(0, 6), 8'h5A);
        do_rd(A(6, 2)); do_rd(A(0, 6));
        idle(P + 2);
        do_rd(A(0, 6)); chk("R10 program during suspend", 8'h5A);
        do_wr(3'd1, A(6, 2), 8'h00);
        idle(P + 2);
        do_rd(A(6, 2));
        tag = "R11";
        do_wr(3'd6, A(0, 0), 8'h00);
        do_rd(A(4, 2));
        idle(2 * (C + 1) + 2);
        do_rd(A(4, 2)); chk("R11 sector 4 erased after resume", 8'hFF);
        do_rd(A(6, 2)); chk("R11 sector 6 erased after resume", 8'hFF);

        // Lock applied after queueing
        tag = "R5";
        prot = 8'h00;
        do_wr(3'd2, A(1, 0), 8'h00);
        prot = 8'h02;
        do_wr(3'd3, A(0, 0), 8'h00);
        idle(C + 3);
        do_rd(A(1, 3)); chk("R5 late lock keeps sector", 8'h24);

        // Chip erase with one locked sector
        tag = "R7";
        prot = 8'h00;
        do_wr(3'd1, A(2, 7), 8'hC3); idle(P + 2);
        prot = 8'h04;
        do_wr(3'd4, A(0, 0), 8'h00);
        do_rd(A(2, 7)); do_rd(A(7, 0));
        idle(7 * (C + 1) + 2);
        do_rd(A(2, 7)); chk("R7 locked sector survives chip erase", 8'hC3);
        do_rd(A(0, 6)); chk("R7 unlocked sector erased", 8'hFF);
        do_rd(A(1, 3)); chk("R7 sector 1 erased", 8'hFF);

        idle(2);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule